// File: doc/BRIEF.md
# Clock Mode Sequencer with Bus Divider

This block decides which clock source drives the core and bus clocks, and which clocking configuration the chip is in. After reset it runs the phase-locked loop from the internal 1 MHz reference. Software moves it to the external reference by enabling the crystal oscillator with the PLL still selected. The move completes only after the PLL reports lock and the oscillator reports that it is running. Clearing the PLL-select bit instead runs the core and bus directly from the oscillator clock. If the oscillator dies while it is in use, the block falls back to the internal-reference PLL mode and keeps a sticky loss flag.

Everything runs on the VCO-rate clock. The bus clock appears as a one-cycle enable, `busEn`. On the PLL path it fires once every 2·(POSTDIV+1) VCO cycles, which is the PLL clock divided by (POSTDIV+1) and then halved for the bus. On the oscillator path it fires on every second oscillator tick, where the oscillator clock arrives as a tick strobe. A change of source passes through a gap cycle in which neither gate is open.

Lock is modelled as a strobe. Any post-divider write clears lock, and the PLL path gives no bus enables until lock is seen again. The block also picks the clock source for the watchdog and periodic-interrupt timers. The oscillator is only granted to them while it is actually in use.

Top module: `clk_mode_seq`

## Requirements
- R1: After reset: `modeCode`=0, `pllRefExt`=0, `pllLocked`=0, `pllGateEn`=1, `oscGateEn`=0, `busEn`=0, `oscStart`=0, `oscLost`=0, `timerSrc`=0. The post-divider reset value is 3.
- R2: While the PLL gate is open and lock is held, `busEn` is high for exactly one cycle in every 2·(POSTDIV+1) clock cycles. POSTDIV is written at address 1, `wrData[3:0]`.
- R3: A post-divider write clears `pllLocked` and a `lockPulse` sets it. While the PLL gate is open and lock is clear, `busEn` stays low.
- R4: `oscStart` follows the oscillator-enable bit, which is control word (address 0) bit 0.
- R5: Mode 0 moves to mode 1 (external-reference PLL, `pllRefExt`=1) only when oscillator-enable, `oscUp`, lock and PLL-select (control bit 1) are all 1.
- R6: With PLL-select 0 and the oscillator enabled and up, the mode becomes 2, the oscillator gate opens, and `busEn` pulses on every second `oscTick`.
- R7: `pllGateEn` and `oscGateEn` are never high together. On a source change both are low for at least one cycle before the new gate opens.
- R8: If `oscUp` drops while in mode 1 or 2, the mode returns to 0 and `oscLost` sets and stays set until reset.
- R9: The timer source request is control bits 3:2. A request of 1 yields code 1 (RC oscillator). A request of 2 yields code 2 (oscillator) only in mode 1 or 2. Every other case yields code 0 (internal reference).
- R10: Clearing oscillator-enable in mode 1 returns the mode to 0 without setting `oscLost`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0 = control word, 1 = post-divider |
| wrData | input | POSTDIV_W | Write data |
| oscUp | input | 1 | Oscillator running status |
| lockPulse | input | 1 | PLL lock detected strobe |
| oscTick | input | 1 | One strobe per oscillator clock period |
| modeCode | output | 2 | 0 internal PLL, 1 external PLL, 2 oscillator direct |
| pllRefExt | output | 1 | PLL reference is the external oscillator |
| pllLocked | output | 1 | Lock flag |
| oscStart | output | 1 | Oscillator enable to the analog cell |
| oscLost | output | 1 | Sticky oscillator-loss flag |
| pllGateEn | output | 1 | Core clock taken from the PLL path |
| oscGateEn | output | 1 | Core clock taken from the oscillator path |
| busEn | output | 1 | Bus clock enable |
| timerSrc | output | 2 | Timer clock source code |

## Verification
The divider is swept over every post-divider value. Each value is preceded by a locked-out stretch, so the bench can tell a wrong period from a wrong lock hold-off. The mode sequencer is driven with lock, oscillator-up and enable arriving in different orders. This separates a transition that waits for all conditions from one that fires on a subset. Source switches in both directions are traced cycle by cycle for the gap. Oscillator loss is distinguished from an intentional disable by the sticky flag.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    MODE_INT_PLL    = 2'd0,
    MODE_EXT_PLL    = 2'd1,
    MODE_OSC_DIRECT = 2'd2
  } clkMode_t;

  typedef enum logic [1:0] {
    TSRC_INTREF = 2'd0,
    TSRC_RC     = 2'd1,
    TSRC_OSC    = 2'd2
  } timerSrc_t;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DIV  = 1'b1;

  localparam int CTRL_OSC_EN  = 0;
  localparam int CTRL_PLL_SEL = 1;
  localparam int CTRL_TMR_LO  = 2;

  typedef struct packed {
    logic pllRun;
    logic oscRun;
    logic restart;
  } divCtl_t;
endpackage

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int POSTDIV_W   = 4,
  parameter int POSTDIV_RST = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [POSTDIV_W-1:0] wrData,
  input  logic                 oscUp,
  input  logic                 lockPulse,
  output clkMode_t             mode,
  output logic                 pllLocked,
  output logic                 oscStart,
  output logic                 oscLost,
  output logic                 pllGateEn,
  output logic                 oscGateEn,
  output timerSrc_t            timerSel,
  output logic [POSTDIV_W-1:0] postDiv,
  output divCtl_t              divCtl
);
  logic       oscEn, pllSel;
  logic [1:0] tmrReq;
  logic       wrCtrl, wrDiv, oscOk;
  clkMode_t   modeNext;
  logic       lostSet;
  logic       curSrcOsc, swGap, wantOsc;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrDiv  = wrEn && (wrAddr == ADDR_DIV);
  assign oscOk  = oscEn && oscUp;

  // software-visible settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oscEn   <= 1'b0;
      pllSel  <= 1'b1;
      tmrReq  <= 2'd0;
      postDiv <= POSTDIV_W'(POSTDIV_RST);
    end else begin
      if (wrCtrl) begin
        oscEn  <= wrData[CTRL_OSC_EN];
        pllSel <= wrData[CTRL_PLL_SEL];
        tmrReq <= wrData[CTRL_TMR_LO+1:CTRL_TMR_LO];
      end
      if (wrDiv) postDiv <= wrData;
    end
  end

  // lock flag: a divider change forces relock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pllLocked <= 1'b0;
    else if (wrDiv)     pllLocked <= 1'b0;
    else if (lockPulse) pllLocked <= 1'b1;
  end

  // configuration mode sequencer
  always_comb begin
    modeNext = mode;
    lostSet  = 1'b0;
    case (mode)
      MODE_INT_PLL: begin
        if (oscOk && !pllSel)                modeNext = MODE_OSC_DIRECT;
        else if (oscOk && pllSel && pllLocked) modeNext = MODE_EXT_PLL;
      end
      MODE_EXT_PLL: begin
        if (!oscOk) begin
          modeNext = MODE_INT_PLL;
          lostSet  = !oscUp;
        end else if (!pllSel) modeNext = MODE_OSC_DIRECT;
      end
      MODE_OSC_DIRECT: begin
        if (!oscOk) begin
          modeNext = MODE_INT_PLL;
          lostSet  = !oscUp;
        end else if (pllSel && pllLocked) modeNext = MODE_EXT_PLL;
      end
      default: modeNext = MODE_INT_PLL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_INT_PLL;
      oscLost <= 1'b0;
    end else begin
      mode <= modeNext;
      if (lostSet) oscLost <= 1'b1;
    end
  end

  // break-before-make source handshake
  assign wantOsc = (mode == MODE_OSC_DIRECT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrcOsc <= 1'b0;
      swGap     <= 1'b0;
    end else if (swGap) begin
      curSrcOsc <= wantOsc;
      swGap     <= 1'b0;
    end else if (wantOsc != curSrcOsc) begin
      swGap <= 1'b1;
    end
  end

  assign pllGateEn = !swGap && !curSrcOsc;
  assign oscGateEn = !swGap && curSrcOsc;
  assign oscStart  = oscEn;

  always_comb begin
    timerSel = TSRC_INTREF;
    if (tmrReq == 2'd1) timerSel = TSRC_RC;
    else if (tmrReq == 2'd2 && mode != MODE_INT_PLL) timerSel = TSRC_OSC;
  end

  assign divCtl.pllRun  = pllGateEn && pllLocked;
  assign divCtl.oscRun  = oscGateEn;
  assign divCtl.restart = wrDiv;
endmodule

// File: rtl/clk_mode_div.sv
module clk_mode_div
  import clk_mode_pkg::*;
#(
  parameter int POSTDIV_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  divCtl_t              divCtl,
  input  logic [POSTDIV_W-1:0] postDiv,
  input  logic                 oscTick,
  output logic                 busEn
);
  localparam int CNT_W = POSTDIV_W + 1;

  logic [CNT_W-1:0] cnt, lastCnt;
  logic             oscPhase, pllHit, oscHit;

  // PLL clock = VCO/(postDiv+1), bus = half of that
  assign lastCnt = {postDiv, 1'b1};
  assign pllHit  = divCtl.pllRun && (cnt == lastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             cnt <= '0;
    else if (divCtl.restart || !divCtl.pllRun) cnt <= '0;
    else if (cnt == lastCnt)               cnt <= '0;
    else                                   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               oscPhase <= 1'b0;
    else if (!divCtl.oscRun) oscPhase <= 1'b0;
    else if (oscTick)        oscPhase <= ~oscPhase;
  end

  assign oscHit = divCtl.oscRun && oscTick && oscPhase;
  assign busEn  = pllHit || oscHit;
endmodule

// File: rtl/clk_mode_seq.sv
module clk_mode_seq
  import clk_mode_pkg::*;
#(
  parameter int POSTDIV_W   = 4,
  parameter int POSTDIV_RST = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrAddr,
  input  logic [POSTDIV_W-1:0] wrData,
  input  logic                 oscUp,
  input  logic                 lockPulse,
  input  logic                 oscTick,
  output logic [1:0]           modeCode,
  output logic                 pllRefExt,
  output logic                 pllLocked,
  output logic                 oscStart,
  output logic                 oscLost,
  output logic                 pllGateEn,
  output logic                 oscGateEn,
  output logic                 busEn,
  output logic [1:0]           timerSrc
);
  clkMode_t             mode;
  timerSrc_t            timerSel;
  divCtl_t              divCtl;
  logic [POSTDIV_W-1:0] postDiv;

  clk_mode_ctrl #(.POSTDIV_W(POSTDIV_W), .POSTDIV_RST(POSTDIV_RST)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .oscUp(oscUp), .lockPulse(lockPulse), .mode(mode), .pllLocked(pllLocked),
    .oscStart(oscStart), .oscLost(oscLost), .pllGateEn(pllGateEn),
    .oscGateEn(oscGateEn), .timerSel(timerSel), .postDiv(postDiv), .divCtl(divCtl)
  );

  clk_mode_div #(.POSTDIV_W(POSTDIV_W)) u_div (
    .clk(clk), .rstN(rstN), .divCtl(divCtl), .postDiv(postDiv),
    .oscTick(oscTick), .busEn(busEn)
  );

  assign modeCode  = mode;
  assign pllRefExt = (mode == MODE_EXT_PLL);
  assign timerSrc  = timerSel;
endmodule

// File: rtl/clk_mode_seq_chk.sv
module clk_mode_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       oscUp,
  input logic [1:0] modeCode,
  input logic       pllLocked,
  input logic       oscLost,
  input logic       pllGateEn,
  input logic       oscGateEn,
  input logic       busEn,
  input logic [1:0] timerSrc
);
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    modeCode != 2'd3);

  a_r3_no_bus_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    (pllGateEn && !pllLocked) |-> !busEn);

  a_r5_ext_entry_gated: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 2'd1 && $past(modeCode) == 2'd0) |-> ($past(pllLocked) && $past(oscUp)));

  a_r7_gates_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pllGateEn && oscGateEn));

  a_r7_osc_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscGateEn) |-> $past(!pllGateEn));

  a_r7_pll_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllGateEn) |-> $past(!oscGateEn));

  a_r8_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    oscLost |=> oscLost);

  a_r9_osc_timer_only_ext: assert property (@(posedge clk) disable iff (!rstN)
    (timerSrc == 2'd2) |-> (modeCode != 2'd0));
endmodule

bind clk_mode_seq clk_mode_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .oscUp(oscUp), .modeCode(modeCode),
  .pllLocked(pllLocked), .oscLost(oscLost), .pllGateEn(pllGateEn),
  .oscGateEn(oscGateEn), .busEn(busEn), .timerSrc(timerSrc)
);

// File: tb/clk_mode_seq_test.sv
module clk_mode_seq_test;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, wrAddr = 1'b0;
  logic [3:0] wrData = 4'd0;
  logic       oscUp = 1'b0, lockPulse = 1'b0, oscTick = 1'b0;
  logic [1:0] modeCode, timerSrc;
  logic       pllRefExt, pllLocked, oscStart, oscLost, pllGateEn, oscGateEn, busEn;

  int checks = 0, errors = 0;

  clk_mode_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .oscUp(oscUp), .lockPulse(lockPulse), .oscTick(oscTick),
    .modeCode(modeCode), .pllRefExt(pllRefExt), .pllLocked(pllLocked),
    .oscStart(oscStart), .oscLost(oscLost), .pllGateEn(pllGateEn),
    .oscGateEn(oscGateEn), .busEn(busEn), .timerSrc(timerSrc)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic wr(input logic a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [3:0] ctrlWord(input logic oscE, input logic pSel, input logic [1:0] tReq);
    return {tReq, pSel, oscE};
  endfunction

  task automatic pulseLock();
    @(negedge clk); lockPulse = 1'b1;
    @(negedge clk); lockPulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int pd, input string tag);
    int first = -1, second = -1;
    for (int i = 0; i < 200 && second < 0; i++) begin
      @(negedge clk);
      if (busEn) begin
        if (first < 0) first = i;
        else second = i;
      end
    end
    chk(tag, second - first, 2 * (pd + 1));
  endtask

  task automatic countBusQuiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busEn) hits++;
    end
    chk(tag, hits, 0);
  endtask

  task automatic traceSwitch(input string tag);
    int both = 0, gap = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pllGateEn && oscGateEn) both++;
      if (!pllGateEn && !oscGateEn) gap++;
    end
    chk({tag, " both gates high"}, both, 0);
    chk({tag, " gap seen"}, int'(gap > 0), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 mode", modeCode, 0);
    chk("R1 refExt", pllRefExt, 0);
    chk("R1 locked", pllLocked, 0);
    chk("R1 pllGate", pllGateEn, 1);
    chk("R1 oscGate", oscGateEn, 0);
    chk("R1 busEn", busEn, 0);
    chk("R1 oscStart", oscStart, 0);
    chk("R1 oscLost", oscLost, 0);
    chk("R1 timerSrc", timerSrc, 0);

    countBusQuiet(20, "R3 no bus before lock");
    pulseLock();
    chk("R3 lock set", pllLocked, 1);
    measure(3, "R2 reset divider period");

    // R2/R3 sweep every divider value
    for (int pd = 0; pd < 16; pd++) begin
      wr(1'b1, 4'(pd));
      chk("R3 lock cleared by divider write", pllLocked, 0);
      countBusQuiet(12, "R3 bus held unlocked");
      pulseLock();
      measure(pd, "R2 divider period");
    end
    wr(1'b1, 4'd3);
    pulseLock();

    // R9 timer source in internal mode
    wr(1'b0, ctrlWord(1'b0, 1'b1, 2'd2)); idle(1);
    chk("R9 osc denied in mode 0", timerSrc, 0);
    wr(1'b0, ctrlWord(1'b0, 1'b1, 2'd1)); idle(1);
    chk("R9 rc", timerSrc, 1);
    wr(1'b0, ctrlWord(1'b0, 1'b1, 2'd3)); idle(1);
    chk("R9 code 3 -> internal", timerSrc, 0);

    // R4/R5 gated entry to external PLL
    wr(1'b0, ctrlWord(1'b1, 1'b1, 2'd0)); idle(1);
    chk("R4 oscStart", oscStart, 1);
    chk("R5 stays 0 without oscUp", modeCode, 0);
    wr(1'b1, 4'd3);
    @(negedge clk); oscUp = 1'b1;
    idle(4);
    chk("R5 stays 0 without lock", modeCode, 0);
    pulseLock();
    idle(2);
    chk("R5 mode ext", modeCode, 1);
    chk("R5 refExt", pllRefExt, 1);
    wr(1'b0, ctrlWord(1'b1, 1'b1, 2'd2)); idle(1);
    chk("R9 osc granted in mode 1", timerSrc, 2);
    measure(3, "R2 period in ext mode");

    // R6/R7 switch to oscillator direct
    wr(1'b0, ctrlWord(1'b1, 1'b0, 2'd0));
    traceSwitch("R7 to osc");
    chk("R6 mode osc", modeCode, 2);
    chk("R6 oscGate", oscGateEn, 1);
    chk("R6 pllGate", pllGateEn, 0);
    begin
      int hits = 0, stray = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); oscTick = 1'b1;
        #2; if (busEn) hits++;
        @(negedge clk); oscTick = 1'b0;
        #2; if (busEn) stray++;
        @(negedge clk);
        #2; if (busEn) stray++;
      end
      chk("R6 bus per two ticks", hits, 5);
      chk("R6 no bus without tick", stray, 0);
    end

    // back to external PLL
    wr(1'b0, ctrlWord(1'b1, 1'b1, 2'd0));
    traceSwitch("R7 to pll");
    chk("R7 mode ext again", modeCode, 1);
    chk("R7 pllGate open", pllGateEn, 1);

    // R10 intentional disable
    wr(1'b0, ctrlWord(1'b0, 1'b1, 2'd0)); idle(2);
    chk("R10 mode 0", modeCode, 0);
    chk("R10 no loss flag", oscLost, 0);
    chk("R4 oscStart off", oscStart, 0);

    // R8 oscillator loss
    wr(1'b0, ctrlWord(1'b1, 1'b1, 2'd0)); idle(2);
    chk("R8 precondition mode 1", modeCode, 1);
    @(negedge clk); oscUp = 1'b0;
    idle(2);
    chk("R8 fallback mode", modeCode, 0);
    chk("R8 loss flag", oscLost, 1);
    oscUp = 1'b1;
    idle(3);
    chk("R5 reentry", modeCode, 1);
    chk("R8 flag sticky", oscLost, 1);
    wr(1'b0, ctrlWord(1'b1, 1'b0, 2'd0)); idle(4);
    chk("R6 mode osc again", modeCode, 2);
    @(negedge clk); oscUp = 1'b0;
    idle(2);
    chk("R8 fallback from osc", modeCode, 0);
    chk("R8 flag still set", oscLost, 1);

    summary();
    $finish;
  end
endmodule